// File: doc/BRIEF.md
# Binary Rate Multiplier Pulse Generator

The block thins a stream of reference strobes into one or more output strobe streams. The average rate of each output is the reference rate scaled by an n-bit code: rate = F·N/2^n. A free-running phase counter advances by one on every reference strobe. On each strobe, exactly one counter bit goes from 0 to 1, except when the counter wraps. That bit picks one of n binary-weighted sub-streams. Counter bit 0 rises on every second strobe, bit 1 on every fourth strobe, and so on.

Each generator gates sub-stream i with code bit n−1−i and merges the gated streams with an OR. At most one sub-stream is active per strobe, so the OR never merges two pulses into one. Several generators share the one phase counter, and each takes its own code. The reference input and every output are one-cycle strobes in the clock domain. Each output strobe is registered and follows its reference strobe by one clock.

Typical use is near-sensor arithmetic done in pulse form. One example is scaling a pulse train by a constant before it feeds an up/down counter.

Top module: `brm_pulse_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the phase counter is cleared to zero and every rate_stb output is low. Because the counter starts at zero, the first strobe after reset makes counter bit 0 rise.
- R2: Each rate_stb is high for exactly the one clock that follows a clock in which ref_stb was high and the selected gated stream was active. Without ref_stb it stays low.
- R3: Code bit n−1 (the MSB) gates the stream of counter bit 0. With only the MSB set, a generator fires on the strobes whose pre-increment count is even, which is the 1st, 3rd, 5th strobe and so on of each cycle.
- R4: Code bit 0 (the LSB) gates the stream of counter bit n−1. With only the LSB set, a generator fires once per cycle, on the strobe whose pre-increment count is 2^(n−1)−1.
- R5: On the strobe whose pre-increment count is all ones, no stream fires, even with the code all ones.
- R6: Over any 2^n consecutive strobes counted from reset, a generator with code N emits exactly N output strobes.
- R7: At most one weighted stream is active per strobe. With the code all ones, a generator therefore fires on 2^n−1 of every 2^n strobes.
- R8: All generators share one counter. Their codes, packed as generator g in code_bus bits [g·n+n−1 : g·n], act independently in the same cycle.
- R9: A code is sampled in the cycle of the strobe it gates. A change takes effect on the next strobe.
- R10: The phase counter advances only on clocks with ref_stb high. Idle clocks do not move the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_stb | input | 1 | Reference strobe, one pulse per cycle high |
| code_bus | input | NUM_GEN*WIDTH | Packed rate codes, one WIDTH-bit field per generator |
| rate_stb | output | NUM_GEN | Output strobe of each generator |

## Verification
Single-bit codes separate the bit-to-stream mapping. An MSB-only code must fire on alternate strobes and an LSB-only code only on the eighth, so a reversed mapping shows up at once. An all-ones code exposes both the silent wrap strobe and any double counting. A sweep of complementary codes on the two generators checks the cycle total N and the independence of the shared-counter channels. Idle gaps, back-to-back strobes and a code change in mid-cycle separate counting strobes from counting clocks and show when the code is sampled.

// File: rtl/brm_pkg.sv
// Package: shared constants and the rising-bit helper for the rate multiplier.
// Assumes counter widths of at most MAX_WIDTH bits.
package brm_pkg;

    localparam int unsigned MAX_WIDTH = 31;

    // One-hot mask of the bit that goes 0->1 when v is incremented.
    // For an all-ones value of width w the mask lands on bit w, which the
    // caller removes by truncating to w bits: the wrap then fires nothing.
    function automatic logic [31:0] rise_of(input logic [31:0] v);
        return (v + 32'd1) & ~v;
    endfunction

endpackage

// File: rtl/brm_phase_ctr.sv
// Phase counter shared by all generators.
// Advances on each reference strobe and reports, as a one-hot vector, the
// counter bit that rises on this strobe (weighted stream select).
// Assumes ref_stb is synchronous to clk.
module brm_phase_ctr #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_stb,
    output logic [WIDTH-1:0] phase,
    output logic [WIDTH-1:0] stream
);

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] rise;

    // Count reference strobes, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (ref_stb) cnt_q <= cnt_q + 1'b1;
    end

    // Rising-bit select for the current count, gated by the strobe.
    always_comb begin
        rise   = WIDTH'(brm_pkg::rise_of(32'(cnt_q)));
        stream = ref_stb ? rise : '0;
    end

    assign phase = cnt_q;

    AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stream));                                          // R7
    AST_STREAM_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (|stream) |-> ref_stb);                                     // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |=> phase == WIDTH'($past(phase) + 1'b1));          // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_stb |=> $stable(phase));                               // R10

endmodule

// File: rtl/brm_rate_gate.sv
// One rate generator: gates the weighted streams by its code, ORs them and
// registers the result as a one-clock output strobe.
// Assumes stream is one-hot or zero, with stream[i] of weight 2^(WIDTH-1-i).
module brm_rate_gate #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] stream,
    input  logic [WIDTH-1:0] code,
    output logic             out_stb
);

    logic [WIDTH-1:0] gated;
    logic             merged;

    // Stream i is paired with code bit WIDTH-1-i (fastest stream to MSB).
    for (genvar i = 0; i < WIDTH; i++) begin : g_pair
        assign gated[i] = stream[i] & code[WIDTH-1-i];
    end

    // Merge the gated streams; at most one is active.
    always_comb merged = |gated;

    // Register the merged pulse into the output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) out_stb <= 1'b0;
        else        out_stb <= merged;
    end

    AST_OUT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> $past(|stream));                                // R2
    AST_ONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gated) <= 1);                                    // R7

endmodule

// File: rtl/brm_pulse_gen.sv
// Top: binary rate multiplier with NUM_GEN generators sharing a counter.
// Output g averages F*code_g/2^WIDTH and lags ref_stb by one clock.
// Assumes 1 <= WIDTH <= 31 and single-cycle reference strobes.
module brm_pulse_gen #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned NUM_GEN = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ref_stb,
    input  logic [NUM_GEN*WIDTH-1:0] code_bus,
    output logic [NUM_GEN-1:0]       rate_stb
);

    localparam int unsigned CODE_BITS = NUM_GEN * WIDTH;

    logic [WIDTH-1:0] phase;
    logic [WIDTH-1:0] stream;

    initial begin
        assert (WIDTH >= 1 && WIDTH <= brm_pkg::MAX_WIDTH)
            else $error("WIDTH out of range");
        assert (CODE_BITS == $bits(code_bus))
            else $error("code bus width mismatch");
    end

    brm_phase_ctr #(.WIDTH(WIDTH)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_stb (ref_stb),
        .phase   (phase),
        .stream  (stream)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        brm_rate_gate #(.WIDTH(WIDTH)) gate_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .stream  (stream),
            .code    (code_bus[g*WIDTH +: WIDTH]),
            .out_stb (rate_stb[g])
        );
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_stb |=> rate_stb == '0);                               // R2
    AST_WRAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stb && (&phase)) |=> rate_stb == '0);                  // R5
    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> rate_stb == '0);                                 // R1

endmodule

// File: tb/brm_pulse_gen_tb_top.sv
// Bench for brm_pulse_gen with WIDTH=4, NUM_GEN=2.
module brm_pulse_gen_tb_top;

    localparam int W  = 4;
    localparam int NG = 2;
    localparam int CYC = 1 << W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_stb = 1'b0;
    logic [NG*W-1:0] code_bus = '0;
    logic [NG-1:0] rate_stb;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    brm_pulse_gen #(.WIDTH(W), .NUM_GEN(NG)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_stb  (ref_stb),
        .code_bus (code_bus),
        .rate_stb (rate_stb)
    );

    localparam int NV = 8;
    localparam logic [W-1:0] VEC_CODE [NV] = '{4'd0, 4'd1, 4'd3, 4'd5, 4'd8, 4'd10, 4'd14, 4'd15};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_stb = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 outputs low in reset", int'(rate_stb), 0);
        rst_n = 1'b1;
    endtask

    // One strobe; returns the outputs in the following clock.
    task automatic pulse(output logic [NG-1:0] o);
        @(negedge clk);
        ref_stb = 1'b1;
        @(negedge clk);
        ref_stb = 1'b0;
        o = rate_stb;
    endtask

    initial begin
        logic [NG-1:0] o;
        int c0, c1;

        do_reset();

        // Table walk: complementary codes over one full cycle (R6, R8).
        for (int v = 0; v < NV; v++) begin
            do_reset();
            code_bus = {~VEC_CODE[v], VEC_CODE[v]};
            c0 = 0; c1 = 0;
            for (int k = 0; k < CYC; k++) begin
                pulse(o);
                c0 += int'(o[0]);
                c1 += int'(o[1]);
            end
            chk("R6 cycle count gen0", c0, int'(VEC_CODE[v]));
            chk("R8 cycle count gen1", c1, CYC - 1 - int'(VEC_CODE[v]));
        end

        // R1 and R3: MSB-only code fires on even pre-counts, first strobe included.
        do_reset();
        code_bus = {4'b0000, 4'b1000};
        for (int k = 0; k < CYC; k++) begin
            pulse(o);
            chk("R3 MSB pattern", int'(o[0]), (k % 2 == 0) ? 1 : 0);
            if (k == 0) chk("R1 first strobe after reset", int'(o[0]), 1);
        end

        // R4: LSB-only code fires on pre-count 7 only.
        do_reset();
        code_bus = {4'b0000, 4'b0001};
        for (int k = 0; k < CYC; k++) begin
            pulse(o);
            chk("R4 LSB pattern", int'(o[0]), (k == 7) ? 1 : 0);
        end

        // R5 and R7: all-ones code fires on all but the wrap strobe.
        do_reset();
        code_bus = {4'b1111, 4'b1111};
        c0 = 0;
        for (int k = 0; k < CYC; k++) begin
            pulse(o);
            c0 += int'(o[0]);
            if (k == CYC - 1) chk("R5 wrap strobe silent", int'(o), 0);
        end
        chk("R7 all-ones total", c0, CYC - 1);

        // R2: strobe lasts one clock, idle clocks stay low.
        do_reset();
        code_bus = {4'b1000, 4'b1000};
        pulse(o);
        chk("R2 strobe one clock late", int'(o), 3);
        @(negedge clk);
        chk("R2 strobe one clock wide", int'(rate_stb), 0);
        repeat (3) @(negedge clk);
        chk("R2 quiet without ref", int'(rate_stb), 0);

        // R2: back-to-back strobes each produce an output (pre-counts 0 and 1).
        do_reset();
        code_bus = {4'b1111, 4'b1111};
        @(negedge clk);
        ref_stb = 1'b1;
        @(negedge clk);
        chk("R2 back-to-back first", int'(rate_stb[0]), 1);
        @(negedge clk);
        ref_stb = 1'b0;
        chk("R2 back-to-back second", int'(rate_stb[0]), 1);

        // R10: idle gaps do not advance the sequence.
        do_reset();
        code_bus = {4'b0000, 4'b0001};
        for (int k = 0; k < 7; k++) begin
            pulse(o);
            repeat (2) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        pulse(o);
        chk("R10 eighth strobe after gaps", int'(o[0]), 1);

        // R9: code change applies from the next strobe.
        do_reset();
        code_bus = {4'b0000, 4'b0000};
        pulse(o);
        chk("R9 zero code silent", int'(o), 0);
        code_bus = {4'b0000, 4'b0100};
        pulse(o);
        chk("R9 new code on pre-count 1", int'(o[0]), 1);
        code_bus = {4'b0000, 4'b0000};
        pulse(o);
        chk("R9 cleared code silent", int'(o[0]), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule